// File: doc/BRIEF.md
# Isochronous Split-IN Completion Tracker

This block follows one isochronous IN transfer that a high-speed host runs for a full-speed device behind a hub's transaction translator. Software loads the byte budget and three 8-bit micro-frame masks: the start-split schedule, the complete-split schedule, and the progress record, which must start empty. Software then strobes the block once per micro-frame with the micro-frame index. For each strobe the block answers with a start-split pulse, a complete-split pulse, or nothing.

After a complete-split, the translator's answer is fed back on the response port. The block then updates the remaining byte count, the progress record and a sticky status word, and decides whether the transfer retires. Retirement is driven only by the translator's answers. A byte count that reaches zero does not end the transfer, because the translator can still hold a trailing full-speed result such as a CRC failure. That result is only delivered by a later scheduled complete-split.

The progress record notes every complete-split the block issues. Before each complete-split, the block compares the record with the schedule to find earlier slots that were skipped, which means data may have been lost.

Top module: `isplit_in_tracker`

## Requirements
- R1: While the tracker is inactive, micro-frame strobes and responses issue nothing and leave the byte count, the progress record and the status unchanged.
- R2: A load is accepted only while the tracker is inactive, and it clears the status. If the loaded progress record is nonzero, status bit 0 (configuration error) is set and the tracker stays inactive. Otherwise the tracker becomes active with the loaded byte count and masks.
- R3: The issue pulse is one cycle long and appears in the cycle after the strobe. A start-split is issued only in a micro-frame whose start-split mask bit is set, and only once. A complete-split is issued only in a micro-frame whose complete-split mask bit is set, and only after the start-split. The two pulses never occur together.
- R4: A data response (PID code 1 = DATA0, 2 = MDATA) whose length fits subtracts that length from the remaining byte count.
- R5: MDATA on a complete-split that is not the last scheduled one keeps the transfer active, even when the byte count reaches zero, and the next scheduled complete-split is still issued.
- R6: DATA0 ends the transfer. Active clears and the retire output pulses for one cycle, whatever byte count remains. A byte count of zero on its own never retires the transfer.
- R7: Status bit 2 (transaction error) is set and the transfer retires in any of these cases: an error response (PID code 4), the error indication asserted with any response, or, on the last scheduled complete-split, no response (PID code 0), NYET (PID code 3) or MDATA.
- R8: A data payload longer than the remaining count sets status bit 3 (babble), clamps the count to zero and retires the transfer.
- R9: NYET or no response on a complete-split that is not the last scheduled one keeps the transfer active, with the count unchanged, until the next scheduled complete-split.
- R10: Each issued complete-split sets its micro-frame bit in the progress record. If any earlier complete-split slot in the schedule is missing from the record at that point, status bit 1 (possible data loss) is set, and the complete-split is still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Load and activate a transfer |
| load_bytes | input | 10 | Byte budget to load |
| load_ss_mask | input | 8 | Start-split micro-frame schedule |
| load_cs_mask | input | 8 | Complete-split micro-frame schedule |
| load_prog | input | 8 | Initial progress record (must be zero) |
| uframe_go | input | 1 | Micro-frame slot strobe |
| uframe_idx | input | 3 | Current micro-frame index |
| rsp_valid | input | 1 | Translator response present |
| rsp_pid | input | 3 | Response code: 0 none, 1 DATA0, 2 MDATA, 3 NYET, 4 error |
| rsp_len | input | 10 | Payload length of the response |
| rsp_err | input | 1 | Translator error indication (for example a CRC failure) |
| issue_ss | output | 1 | Start-split issue pulse |
| issue_cs | output | 1 | Complete-split issue pulse |
| issue_idx | output | 3 | Micro-frame of the last issue |
| active | output | 1 | Transfer in progress |
| bytes_left | output | 10 | Remaining byte count |
| prog_mask | output | 8 | Progress record |
| status | output | 4 | Sticky status: [0] config, [1] data loss, [2] transaction error, [3] babble |
| retire | output | 1 | One-cycle retirement pulse |

## Verification
The hardest situation to reach is an MDATA response that drains the byte count to zero while a complete-split is still scheduled, followed by a last answer that carries the error indication. The stimulus drives exactly that sequence. It checks that the transfer stays active after the count reaches zero, and that the late error lands in the status only when the last complete-split is answered. Skipped slots are reached by withholding the strobe for one scheduled micro-frame before the next one.

// File: rtl/isplit_pkg.sv
package isplit_pkg;
   typedef enum logic [2:0] {
      PID_NONE  = 3'd0,
      PID_DATA0 = 3'd1,
      PID_MDATA = 3'd2,
      PID_NYET  = 3'd3,
      PID_ERR   = 3'd4
   } pid_e;

   localparam int ST_W      = 4;
   localparam int ST_CFG    = 0;
   localparam int ST_MISS   = 1;
   localparam int ST_XACT   = 2;
   localparam int ST_BABBLE = 3;
endpackage

// File: rtl/isplit_sched.sv
module isplit_sched #(
   parameter int UFRAMES = 8,
   localparam int IDX_W = $clog2(UFRAMES)
) (
   input  logic [UFRAMES-1:0] ss_mask,
   input  logic [UFRAMES-1:0] cs_mask,
   input  logic [UFRAMES-1:0] prog,
   input  logic [IDX_W-1:0]   idx,
   output logic               ss_hit,
   output logic               cs_hit,
   output logic               cs_last,
   output logic               cs_gap
);
   logic [UFRAMES-1:0] below;
   logic [UFRAMES-1:0] above;

   for (genvar i = 0; i < UFRAMES; i++) begin : g_slot
      assign below[i] = (IDX_W'(i) < idx);
      assign above[i] = (IDX_W'(i) > idx);
   end

   assign ss_hit  = ss_mask[idx];
   assign cs_hit  = cs_mask[idx];
   assign cs_last = cs_hit && ((cs_mask & above) == '0);
   assign cs_gap  = |(cs_mask & below & ~prog);
endmodule

// File: rtl/isplit_rsp.sv
module isplit_rsp
   import isplit_pkg::*;
#(
   parameter int BYTE_W = 10,
   parameter int LEN_W  = 10
) (
   input  pid_e              pid,
   input  logic [LEN_W-1:0]  len,
   input  logic              err,
   input  logic [BYTE_W-1:0] bytes,
   input  logic              last,
   output logic [BYTE_W-1:0] next_bytes,
   output logic              set_xact,
   output logic              set_babble,
   output logic              done
);
   logic              is_data;
   logic              over;
   logic [BYTE_W-1:0] len_x;

   if (LEN_W > BYTE_W) begin : g_badw
      $error("isplit_rsp: LEN_W must not exceed BYTE_W");
   end

   always_comb begin
      len_x      = BYTE_W'(len);
      is_data    = (pid == PID_DATA0) || (pid == PID_MDATA);
      over       = is_data && (len_x > bytes);
      next_bytes = bytes;
      if (is_data) next_bytes = over ? '0 : bytes - len_x;
      set_babble = over;
      set_xact   = !over && (err || (pid == PID_ERR) ||
                   (last && ((pid == PID_NONE) || (pid == PID_NYET) || (pid == PID_MDATA))));
      done       = over || set_xact || (pid == PID_DATA0);
   end
endmodule

// File: rtl/isplit_in_tracker.sv
module isplit_in_tracker
   import isplit_pkg::*;
#(
   parameter int UFRAMES = 8,
   parameter int BYTE_W  = 10,
   parameter int LEN_W   = 10,
   localparam int IDX_W  = $clog2(UFRAMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [BYTE_W-1:0]  load_bytes,
   input  logic [UFRAMES-1:0] load_ss_mask,
   input  logic [UFRAMES-1:0] load_cs_mask,
   input  logic [UFRAMES-1:0] load_prog,
   input  logic               uframe_go,
   input  logic [IDX_W-1:0]   uframe_idx,
   input  logic               rsp_valid,
   input  logic [2:0]         rsp_pid,
   input  logic [LEN_W-1:0]   rsp_len,
   input  logic               rsp_err,
   output logic               issue_ss,
   output logic               issue_cs,
   output logic [IDX_W-1:0]   issue_idx,
   output logic               active,
   output logic [BYTE_W-1:0]  bytes_left,
   output logic [UFRAMES-1:0] prog_mask,
   output logic [ST_W-1:0]    status,
   output logic               retire
);
   if (UFRAMES < 2 || (1 << IDX_W) != UFRAMES) begin : g_bad_uf
      $error("isplit_in_tracker: UFRAMES must be a power of two >= 2");
   end

   logic               active_q, ss_done_q, wait_q, last_q;
   logic [BYTE_W-1:0]  bytes_q;
   logic [UFRAMES-1:0] prog_q, ss_q, cs_q;
   logic [ST_W-1:0]    status_q;
   logic               issue_ss_q, issue_cs_q, retire_q;
   logic [IDX_W-1:0]   issue_idx_q;

   logic ss_hit, cs_hit, cs_last, cs_gap;
   logic [BYTE_W-1:0] next_bytes;
   logic set_xact, set_babble, done;
   pid_e pid;

   assign pid = pid_e'(rsp_pid);

   isplit_sched #(.UFRAMES(UFRAMES)) u_sched (
      .ss_mask(ss_q), .cs_mask(cs_q), .prog(prog_q), .idx(uframe_idx),
      .ss_hit(ss_hit), .cs_hit(cs_hit), .cs_last(cs_last), .cs_gap(cs_gap)
   );

   isplit_rsp #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_rsp (
      .pid(pid), .len(rsp_len), .err(rsp_err), .bytes(bytes_q), .last(last_q),
      .next_bytes(next_bytes), .set_xact(set_xact), .set_babble(set_babble), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q    <= 1'b0;
         ss_done_q   <= 1'b0;
         wait_q      <= 1'b0;
         last_q      <= 1'b0;
         bytes_q     <= '0;
         prog_q      <= '0;
         ss_q        <= '0;
         cs_q        <= '0;
         status_q    <= '0;
         issue_ss_q  <= 1'b0;
         issue_cs_q  <= 1'b0;
         issue_idx_q <= '0;
         retire_q    <= 1'b0;
      end else begin
         issue_ss_q <= 1'b0;
         issue_cs_q <= 1'b0;
         retire_q   <= 1'b0;
         if (!active_q) begin
            if (load) begin
               status_q  <= '0;
               ss_done_q <= 1'b0;
               wait_q    <= 1'b0;
               if (load_prog != '0) begin
                  status_q[ST_CFG] <= 1'b1;
               end else begin
                  active_q <= 1'b1;
                  bytes_q  <= load_bytes;
                  ss_q     <= load_ss_mask;
                  cs_q     <= load_cs_mask;
                  prog_q   <= '0;
               end
            end
         end else if (!wait_q) begin
            if (uframe_go) begin
               if (ss_hit && !ss_done_q) begin
                  issue_ss_q  <= 1'b1;
                  issue_idx_q <= uframe_idx;
                  ss_done_q   <= 1'b1;
               end else if (cs_hit && ss_done_q) begin
                  issue_cs_q  <= 1'b1;
                  issue_idx_q <= uframe_idx;
                  wait_q      <= 1'b1;
                  last_q      <= cs_last;
                  prog_q      <= prog_q | (UFRAMES'(1) << uframe_idx);
                  if (cs_gap) status_q[ST_MISS] <= 1'b1;
               end
            end
         end else if (rsp_valid) begin
            wait_q  <= 1'b0;
            bytes_q <= next_bytes;
            if (set_xact)   status_q[ST_XACT]   <= 1'b1;
            if (set_babble) status_q[ST_BABBLE] <= 1'b1;
            if (done) begin
               active_q <= 1'b0;
               retire_q <= 1'b1;
            end
         end
      end
   end

   assign issue_ss   = issue_ss_q;
   assign issue_cs   = issue_cs_q;
   assign issue_idx  = issue_idx_q;
   assign active     = active_q;
   assign bytes_left = bytes_q;
   assign prog_mask  = prog_q;
   assign status     = status_q;
   assign retire     = retire_q;

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !load) |=> (!issue_ss_q && !issue_cs_q && $stable(bytes_q) && $stable(prog_q)));

   p_single_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_ss_q && issue_cs_q));

   p_cs_in_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_cs_q |-> cs_q[issue_idx_q]);

   p_mdata_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && wait_q && rsp_valid && pid == PID_MDATA && !last_q && !rsp_err &&
       BYTE_W'(rsp_len) <= bytes_q) |=> active_q);

   p_retire_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      retire_q |-> !active_q);

   p_babble_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[ST_BABBLE]) |-> (bytes_q == '0));

   p_prog_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |=> (!active_q || ((prog_q & $past(prog_q)) == $past(prog_q))));
endmodule

// File: tb/sim_isplit_in_tracker.sv
`timescale 1ns/1ps
module sim_isplit_in_tracker;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst_n = 0;
   logic load = 0;
   logic [9:0] load_bytes = 0;
   logic [7:0] load_ss_mask = 0, load_cs_mask = 0, load_prog = 0;
   logic uframe_go = 0;
   logic [2:0] uframe_idx = 0;
   logic rsp_valid = 0;
   logic [2:0] rsp_pid = 0;
   logic [9:0] rsp_len = 0;
   logic rsp_err = 0;
   logic issue_ss, issue_cs, active, retire;
   logic [2:0] issue_idx;
   logic [9:0] bytes_left;
   logic [7:0] prog_mask;
   logic [3:0] status;

   int checks = 0, fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   isplit_in_tracker u0 (
      .clk(clk), .rst_n(rst_n), .load(load), .load_bytes(load_bytes),
      .load_ss_mask(load_ss_mask), .load_cs_mask(load_cs_mask), .load_prog(load_prog),
      .uframe_go(uframe_go), .uframe_idx(uframe_idx), .rsp_valid(rsp_valid),
      .rsp_pid(rsp_pid), .rsp_len(rsp_len), .rsp_err(rsp_err),
      .issue_ss(issue_ss), .issue_cs(issue_cs), .issue_idx(issue_idx), .active(active),
      .bytes_left(bytes_left), .prog_mask(prog_mask), .status(status), .retire(retire)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_load(input int b, input int ss, input int cs, input int pg);
      @(negedge clk);
      load = 1; load_bytes = 10'(b); load_ss_mask = 8'(ss);
      load_cs_mask = 8'(cs); load_prog = 8'(pg);
      @(negedge clk);
      load = 0;
   endtask

   task automatic tick(input int k);
      @(negedge clk);
      uframe_go = 1; uframe_idx = 3'(k);
      @(negedge clk);
      uframe_go = 0;
   endtask

   task automatic rsp(input int pid, input int len, input bit err);
      @(negedge clk);
      rsp_valid = 1; rsp_pid = 3'(pid); rsp_len = 10'(len); rsp_err = err;
      @(negedge clk);
      rsp_valid = 0; rsp_err = 0;
   endtask

   task automatic t_reset();
      chk("R1 reset active", int'(active), 0);
      chk("R1 reset status", int'(status), 0);
      chk("R1 reset bytes", int'(bytes_left), 0);
   endtask

   task automatic t_cfg_err();
      do_load(50, 8'h01, 8'h1C, 8'h04);
      chk("R2 cfg status", int'(status), 1);
      chk("R2 cfg inactive", int'(active), 0);
      tick(0);
      chk("R1 no issue inactive", int'(issue_ss | issue_cs), 0);
      rsp(1, 5, 0);
      chk("R1 rsp ignored bytes", int'(bytes_left), 0);
      chk("R1 rsp ignored retire", int'(retire), 0);
   endtask

   task automatic t_normal();
      do_load(100, 8'h01, 8'h1C, 0);
      chk("R2 active", int'(active), 1);
      chk("R2 status cleared", int'(status), 0);
      tick(0);
      chk("R3 ss issued", int'(issue_ss), 1);
      chk("R3 ss idx", int'(issue_idx), 0);
      tick(1);
      chk("R3 nothing in unscheduled slot", int'(issue_ss | issue_cs), 0);
      tick(2);
      chk("R3 cs issued", int'(issue_cs), 1);
      chk("R10 prog bit2", int'(prog_mask), 8'h04);
      rsp(2, 60, 0);
      chk("R4 subtract", int'(bytes_left), 40);
      do_load(7, 0, 0, 0);
      chk("R2 load ignored while active", int'(bytes_left), 40);
      tick(3);
      chk("R3 cs again", int'(issue_cs), 1);
      rsp(2, 40, 0);
      chk("R5 count zero", int'(bytes_left), 0);
      chk("R5 stays active", int'(active), 1);
      chk("R6 no retire on zero", int'(retire), 0);
      tick(4);
      chk("R5 last cs still issued", int'(issue_cs), 1);
      rsp(1, 0, 0);
      chk("R6 retire pulse", int'(retire), 1);
      chk("R6 inactive", int'(active), 0);
      chk("R10 no miss", int'(status), 0);
      @(negedge clk);
      chk("R6 retire one cycle", int'(retire), 0);
   endtask

   task automatic t_late_crc();
      do_load(30, 8'h01, 8'h0C, 0);
      tick(0); tick(2);
      rsp(2, 30, 0);
      chk("R5 active after drain", int'(active), 1);
      tick(3);
      rsp(1, 0, 1);
      chk("R7 late crc status", int'(status), 4);
      chk("R7 retired", int'(active), 0);
   endtask

   task automatic t_babble();
      do_load(10, 8'h01, 8'h0C, 0);
      tick(0); tick(2);
      rsp(2, 20, 0);
      chk("R8 babble status", int'(status), 8);
      chk("R8 clamp", int'(bytes_left), 0);
      chk("R8 retired", int'(active), 0);
   endtask

   task automatic t_nyet();
      do_load(40, 8'h01, 8'h0C, 0);
      tick(0); tick(2);
      rsp(3, 0, 0);
      chk("R9 nyet keeps active", int'(active), 1);
      chk("R9 count unchanged", int'(bytes_left), 40);
      tick(3);
      chk("R9 next cs", int'(issue_cs), 1);
      rsp(3, 0, 0);
      chk("R7 nyet on last", int'(status), 4);
      chk("R7 retire", int'(active), 0);
   endtask

   task automatic t_error_pid();
      do_load(40, 8'h01, 8'h0C, 0);
      tick(0); tick(2);
      rsp(4, 0, 0);
      chk("R7 err pid status", int'(status), 4);
      chk("R7 err pid retired", int'(active), 0);
   endtask

   task automatic t_miss();
      do_load(40, 8'h01, 8'h1C, 0);
      tick(0); tick(1); tick(3);
      chk("R10 cs issued despite gap", int'(issue_cs), 1);
      chk("R10 miss flagged", int'(status), 2);
      chk("R10 prog bit3 only", int'(prog_mask), 8'h08);
      rsp(1, 10, 0);
      chk("R6 data0 retires with bytes left", int'(active), 0);
      chk("R4 data0 subtract", int'(bytes_left), 30);
   endtask

   initial begin : wd
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_cfg_err();
      t_normal();
      t_late_crc();
      t_babble();
      t_nyet();
      t_error_pid();
      t_miss();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule